// File: doc/BRIEF.md
# Hot Trace Detector

This block watches the stream of retired instructions and finds frequently executed branch targets. Each taken branch increments a counter for its target. The counters live in a small direct-mapped table, and each entry carries a tag so that two targets sharing a slot are told apart. When a target's counter reaches the hot threshold, the block raises a start event and becomes a recorder. Every instruction that retires after that is sent out as one element of a candidate trace. The trace is whatever path happens to execute next.

Recording stops at the first of three conditions: an indirect jump retires, the trace reaches its maximum length, or a taken branch jumps back to the trace's own starting address. The end event reports which condition applied and how long the trace is. Any later hot target starts a new trace, including a side exit out of a trace recorded earlier. A translation layer downstream consumes the events and builds superblocks from them.

Top module: `hot_trace_detector`

## Requirements
- R1: After reset the outputs trc_start, rec_valid and trc_end are 0 and every counter entry is empty.
- R2: A retired taken branch (ret_valid=1, ret_taken=1) increments the counter of ret_target. The increment that brings the counter to HOT_THRESH (default 32) makes trc_start=1 one cycle later, with trc_start_pc equal to that target. The 31st increment raises nothing.
- R3: The counter table is indexed by ret_target[IDX_W+1:2] and tagged with the bits above that index. A taken branch whose tag differs from the stored one replaces the entry, and the new entry's count restarts at 1.
- R4: While recording, each retired instruction gives rec_valid=1 one cycle later, with rec_pc equal to its ret_pc. The branch that triggered the trace is not itself recorded.
- R5: A recorded instruction with ret_indirect=1 ends the trace. trc_end=1 appears in the same cycle as that instruction's record, with trc_end_reason=1, and the instruction counts toward trc_len.
- R6: The MAX_LEN-th recorded instruction (default 256) ends the trace with trc_end_reason=2 and trc_len=MAX_LEN. No instruction after it is recorded.
- R7: A recorded taken branch whose target equals the trace's start address ends the trace with trc_end_reason=3.
- R8: When several end conditions hold on one instruction, indirect (1) wins over loop back (3), and loop back wins over the length limit (2).
- R9: No trace starts while a recording is active. A counter that would reach HOT_THRESH during recording is held at HOT_THRESH-1, so the next taken branch to that target after the trace ends starts a trace.
- R10: A target's counter is cleared when its trace starts, so a further HOT_THRESH increments are needed before that target starts another trace.
- R11: Retired instructions that are not taken branches, and cycles with ret_valid=0, leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A retired instruction is presented |
| ret_pc | input | PC_W | Address of the retired instruction |
| ret_taken | input | 1 | The instruction was a taken branch |
| ret_target | input | PC_W | Branch target when taken |
| ret_indirect | input | 1 | The instruction was an indirect jump |
| trc_start | output | 1 | One-cycle pulse: a trace begins |
| trc_start_pc | output | PC_W | Hot target that opened the trace |
| rec_valid | output | 1 | One recorded trace element |
| rec_pc | output | PC_W | Address of the recorded element |
| trc_end | output | 1 | One-cycle pulse: the trace is closed |
| trc_end_reason | output | 2 | 1 indirect, 2 length limit, 3 loop back |
| trc_len | output | LEN_W | Number of recorded elements in the closed trace |

## Verification
The bench counts the threshold exactly from both sides of 32. A design off by one would start a trace on the 31st or 33rd branch. Not-taken instructions and empty cycles are mixed into the counting, so a design that counts them would fire early. Two targets that share a table slot are alternated, and a design without a tag check would fire before the restart count reaches 32. The bench also hits a counter that reaches the threshold during a recording: a design without saturation would either start a nested trace or lose the hot state. Traces of exactly 256 elements are closed both by the length limit and by a loop back on that same element, and a further trace has an indirect jump branching to its own start, so a wrong priority shows up as a wrong reason code.

// File: rtl/htd_pkg.sv
package htd_pkg;
  typedef enum logic [1:0] {
    END_NONE     = 2'd0,
    END_INDIRECT = 2'd1,
    END_LENGTH   = 2'd2,
    END_LOOP     = 2'd3
  } end_reason_e;
endpackage

// File: rtl/htd_count_table.sv
module htd_count_table #(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 4,
  parameter int HOT_THRESH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            arm_ok_i,
  output logic            fire_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;
  localparam int CNT_W   = $clog2(HOT_THRESH + 1);
  localparam logic [CNT_W-1:0] HOT_C = CNT_W'(HOT_THRESH);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOT_THRESH - 1);

  function automatic logic [CNT_W-1:0] bump(input logic hit, input logic [CNT_W-1:0] cur);
    return hit ? cur + CNT_W'(1) : CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] settle(input logic fired, input logic [CNT_W-1:0] nxt);
    if (fired) return '0;
    return (nxt >= HOT_C) ? HOLD_C : nxt;
  endfunction

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    idx    = target_i[IDX_W+1:2];
    tag    = target_i[PC_W-1:IDX_W+2];
    hit    = vld_q[idx] && (tag_q[idx] == tag);
    nxt    = bump(hit, cnt_q[idx]);
    fire_o = upd_i && arm_ok_i && (nxt == HOT_C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (upd_i) begin
      vld_q[idx] <= 1'b1;
      tag_q[idx] <= tag;
      cnt_q[idx] <= settle(fire_o, nxt);
    end
  end
endmodule

// File: rtl/htd_recorder.sv
module htd_recorder
  import htd_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int MAX_LEN = 256,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [PC_W-1:0]  fire_pc_i,
  input  logic             ret_valid,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic             ret_taken,
  input  logic [PC_W-1:0]  ret_target,
  input  logic             ret_indirect,
  output logic             active_o,
  output logic             end_now_o,
  output logic             start_o,
  output logic [PC_W-1:0]  start_pc_o,
  output logic             rec_valid_o,
  output logic [PC_W-1:0]  rec_pc_o,
  output logic             end_o,
  output logic [1:0]       reason_o,
  output logic [LEN_W-1:0] len_o
);
  function automatic end_reason_e classify(input logic ind, input logic loop_back, input logic full);
    if (ind)       return END_INDIRECT;
    if (loop_back) return END_LOOP;
    if (full)      return END_LENGTH;
    return END_NONE;
  endfunction

  logic             active_q;
  logic [PC_W-1:0]  origin_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_next;
  logic             take;
  end_reason_e      why;

  always_comb begin
    len_next  = len_q + LEN_W'(1);
    take      = active_q && ret_valid;
    why       = classify(ret_indirect, ret_taken && (ret_target == origin_q),
                         len_next == LEN_W'(MAX_LEN));
    end_now_o = take && (why != END_NONE);
    active_o  = active_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      origin_q    <= '0;
      len_q       <= '0;
      start_o     <= 1'b0;
      start_pc_o  <= '0;
      rec_valid_o <= 1'b0;
      rec_pc_o    <= '0;
      end_o       <= 1'b0;
      reason_o    <= 2'd0;
      len_o       <= '0;
    end else begin
      start_o     <= fire_i;
      rec_valid_o <= take;
      end_o       <= end_now_o;
      if (fire_i) begin
        active_q   <= 1'b1;
        origin_q   <= fire_pc_i;
        start_pc_o <= fire_pc_i;
        len_q      <= '0;
      end
      if (take) begin
        rec_pc_o <= ret_pc;
        len_q    <= len_next;
        if (end_now_o) begin
          active_q <= 1'b0;
          reason_o <= why;
          len_o    <= len_next;
        end
      end
    end
  end
endmodule

// File: rtl/hot_trace_detector.sv
module hot_trace_detector #(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 4,
  parameter int HOT_THRESH = 32,
  parameter int MAX_LEN    = 256,
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic             ret_taken,
  input  logic [PC_W-1:0]  ret_target,
  input  logic             ret_indirect,
  output logic             trc_start,
  output logic [PC_W-1:0]  trc_start_pc,
  output logic             rec_valid,
  output logic [PC_W-1:0]  rec_pc,
  output logic             trc_end,
  output logic [1:0]       trc_end_reason,
  output logic [LEN_W-1:0] trc_len
);
  logic count_upd;
  logic hot_fire;
  logic rec_active;
  logic rec_end_now;

  assign count_upd = ret_valid && ret_taken;

  htd_count_table #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HOT_THRESH(HOT_THRESH)
  ) table_i (
    .clk(clk), .rst_n(rst_n), .upd_i(count_upd), .target_i(ret_target),
    .arm_ok_i(!rec_active), .fire_o(hot_fire)
  );

  htd_recorder #(
    .PC_W(PC_W), .MAX_LEN(MAX_LEN)
  ) rec_i (
    .clk(clk), .rst_n(rst_n), .fire_i(hot_fire), .fire_pc_i(ret_target),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_taken(ret_taken),
    .ret_target(ret_target), .ret_indirect(ret_indirect),
    .active_o(rec_active), .end_now_o(rec_end_now),
    .start_o(trc_start), .start_pc_o(trc_start_pc),
    .rec_valid_o(rec_valid), .rec_pc_o(rec_pc),
    .end_o(trc_end), .reason_o(trc_end_reason), .len_o(trc_len)
  );
endmodule

// File: rtl/htd_checker.sv
module htd_checker #(
  parameter int MAX_LEN = 256,
  parameter int LEN_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid,
  input logic             rec_active,
  input logic             rec_end_now,
  input logic             trc_start,
  input logic             rec_valid,
  input logic             trc_end,
  input logic [1:0]       trc_end_reason,
  input logic [LEN_W-1:0] trc_len
);
  p_start_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trc_start |-> !$past(rec_active));
  p_start_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trc_start |-> rec_active);
  p_record_needs_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> ($past(rec_active) && $past(ret_valid)));
  p_end_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_end_now |=> (trc_end && rec_valid && !rec_active));
  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trc_end |-> (trc_len != '0 && trc_len <= LEN_W'(MAX_LEN)));
  p_reason_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trc_end |-> (trc_end_reason != 2'd0));
endmodule

bind hot_trace_detector htd_checker #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .rec_active(rec_active),
  .rec_end_now(rec_end_now), .trc_start(trc_start), .rec_valid(rec_valid),
  .trc_end(trc_end), .trc_end_reason(trc_end_reason), .trc_len(trc_len)
);

// File: tb/hot_trace_detector_tb_top.sv
module hot_trace_detector_tb_top;
  localparam int PC_W = 32;
  localparam int THR  = 32;
  localparam int MAXL = 256;
  localparam int LEN_W = $clog2(MAXL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret_valid = 1'b0;
  logic [PC_W-1:0] ret_pc = '0;
  logic ret_taken = 1'b0;
  logic [PC_W-1:0] ret_target = '0;
  logic ret_indirect = 1'b0;
  logic trc_start;
  logic [PC_W-1:0] trc_start_pc;
  logic rec_valid;
  logic [PC_W-1:0] rec_pc;
  logic trc_end;
  logic [1:0] trc_end_reason;
  logic [LEN_W-1:0] trc_len;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hot_trace_detector dut_i (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_taken(ret_taken), .ret_target(ret_target), .ret_indirect(ret_indirect),
    .trc_start(trc_start), .trc_start_pc(trc_start_pc), .rec_valid(rec_valid),
    .rec_pc(rec_pc), .trc_end(trc_end), .trc_end_reason(trc_end_reason),
    .trc_len(trc_len)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic retire(input logic [31:0] pc, input logic tk, input logic [31:0] tg, input logic ind);
    @(negedge clk);
    ret_valid = 1'b1; ret_pc = pc; ret_taken = tk; ret_target = tg; ret_indirect = ind;
    @(posedge clk);
    #1;
    ret_valid = 1'b0; ret_taken = 1'b0; ret_indirect = 1'b0;
  endtask

  // n taken branches to tg; the last one starts a trace when fire_last is set
  task automatic heat(input logic [31:0] tg, input int n, input bit fire_last, input string req);
    for (int i = 1; i <= n; i++) begin
      retire(32'h500, 1'b1, tg, 1'b0);
      if (i == n && fire_last) begin
        chk(trc_start == 1'b1, req, trc_start, 1);
        chk(trc_start_pc == tg, req, trc_start_pc, tg);
      end else begin
        chk(trc_start == 1'b0, req, trc_start, 0);
      end
    end
  endtask

  task automatic expect_end(input int reason, input int len, input string req);
    chk(trc_end == 1'b1, req, trc_end, 1);
    chk(trc_end_reason == 2'(reason), req, trc_end_reason, reason);
    chk(trc_len == LEN_W'(len), req, trc_len, len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb, pc3, pd, pe;
    pa = 32'h1000; pb = 32'h2004; pc3 = 32'h3008; pd = 32'h400C; pe = 32'h1040;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: idle outputs after reset
    chk(trc_start == 0 && rec_valid == 0 && trc_end == 0, "R1", {trc_start, rec_valid, trc_end}, 0);

    // R2, R11: 31 taken branches with non-taken and idle cycles mixed in
    for (int i = 1; i <= THR - 1; i++) begin
      retire(32'h500, 1'b1, pa, 1'b0);
      chk(trc_start == 0, "R2", trc_start, 0);
      retire(32'h504, 1'b0, pa, 1'b0);
      chk(trc_start == 0, "R11", trc_start, 0);
      @(posedge clk); #1;
    end
    retire(32'h500, 1'b1, pa, 1'b0);
    chk(trc_start == 1, "R2", trc_start, 1);
    chk(trc_start_pc == pa, "R2", trc_start_pc, pa);

    // R4, R5: record three instructions, indirect closes
    retire(pa, 1'b0, 0, 1'b0);
    chk(rec_valid == 1 && rec_pc == pa && trc_end == 0, "R4", rec_pc, pa);
    retire(pa + 4, 1'b0, 0, 1'b0);
    chk(rec_valid == 1 && rec_pc == pa + 4, "R4", rec_pc, pa + 4);
    retire(pa + 8, 1'b0, 0, 1'b1);
    chk(rec_valid == 1 && rec_pc == pa + 8, "R5", rec_pc, pa + 8);
    expect_end(1, 3, "R5");
    @(posedge clk); #1;
    chk(rec_valid == 0 && trc_end == 0, "R5", {rec_valid, trc_end}, 0);

    // R10: counter was cleared, needs a full 32 again; R7 loop back
    heat(pa, THR, 1'b1, "R10");
    retire(pa, 1'b0, 0, 1'b0);
    chk(trc_end == 0, "R7", trc_end, 0);
    retire(pa + 4, 1'b1, pa, 1'b0);   // counts pa once (now 1)
    expect_end(3, 2, "R7");

    // R9: counter reaching threshold during recording is held below it
    heat(pb, THR - 1, 1'b0, "R9");
    heat(pc3, THR, 1'b1, "R9");
    retire(pc3, 1'b1, pb, 1'b0);
    chk(trc_start == 0 && rec_valid == 1, "R9", trc_start, 0);
    retire(pc3 + 4, 1'b0, 0, 1'b1);
    expect_end(1, 2, "R9");
    retire(32'h500, 1'b1, pb, 1'b0);
    chk(trc_start == 1 && trc_start_pc == pb, "R9", trc_start_pc, pb);
    // R8: indirect jump to the start address reports indirect
    retire(pb, 1'b1, pb, 1'b1);
    expect_end(1, 1, "R8");

    // R8: loop back on the 256th element wins over length
    heat(pd, THR, 1'b1, "R2");
    for (int i = 0; i < MAXL; i++) begin
      retire(pd + 4 * i, (i == MAXL - 1), pd, 1'b0);
      chk(rec_valid == 1 && rec_pc == pd + 4 * i, "R4", rec_pc, pd + 4 * i);
      if (i < MAXL - 1) chk(trc_end == 0, "R8", trc_end, 0);
    end
    expect_end(3, MAXL, "R8");

    // R6: plain length limit (pd counted once by the last branch above)
    heat(pd, THR - 1, 1'b1, "R10");
    for (int i = 0; i < MAXL; i++) begin
      retire(pd + 4 * i, 1'b0, 0, 1'b0);
      if (i < MAXL - 1) chk(trc_end == 0, "R6", trc_end, 0);
    end
    expect_end(2, MAXL, "R6");
    retire(32'h600, 1'b0, 0, 1'b0);
    chk(rec_valid == 0 && trc_end == 0, "R6", rec_valid, 0);

    // R3: aliasing target in the same slot restarts the count (pa is at 1)
    heat(pa, 20, 1'b0, "R3");
    retire(32'h500, 1'b1, pe, 1'b0);
    chk(trc_start == 0, "R3", trc_start, 0);
    heat(pa, THR, 1'b1, "R3");
    retire(pa, 1'b0, 0, 1'b1);
    expect_end(1, 1, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule